// File: doc/BRIEF.md
# Double-Buffered Serial I/O Port

This block links a byte-wide processor bus to a single-wire serial device in each direction. On the receive side, bits arrive one per receive-tick and collect in a shift register. When a byte is complete it is copied as a whole into a holding register that the processor reads. The shifter is then free at once for the next byte. On the transmit side, the processor writes a byte into a holding register. That byte moves into an output shifter as soon as the shifter is idle, and the shifter drives it onto the line one bit per transmit-tick.

The receive and transmit bit rates are set outside the block by two independent single-cycle tick inputs. Framing and rate generation are not part of this block. Both directions hold one byte in the holding register and a second in the shifter, so a slow processor gains one full byte time of slack. An interrupt line reports "byte waiting" and "room for a byte", and each of the two conditions has its own enable bit.

Top module: `sio_dbuf`

## Requirements
- R1: After reset, the status register reads 8'h02 (only tx-empty set), `intr` is 0, `tx_bit` is 1 and `accept` is 0.
- R2: On each `rx_tick` the bit on `rx_bit` is taken, least significant bit first. On the eighth tick the whole byte is copied into the receive holding register and rx-full (status bit 0) becomes 1.
- R3: A read with `rs`=0 returns the receive holding register and clears rx-full.
- R4: While the holding register still holds an unread byte, the receive shifter keeps accepting bits. A byte read out in the middle of the next byte comes back unchanged, and the next byte then arrives intact.
- R5: If a byte completes while rx-full is 1 and the holding register is not being read in the same cycle, the overrun flag (status bit 2) is set and the new byte replaces the old one. Any write with `rs`=1 clears overrun.
- R6: A write with `rs`=0 loads the transmit holding register and clears tx-empty (status bit 1). While the shifter is idle, the byte moves into it on the next clock and tx-empty returns to 1. The shifter drives bit 0 first and advances one bit per `tx_tick`. After the eighth tick `tx_bit` returns to 1 (idle).
- R7: A byte written while the shifter is busy waits in the holding register, and tx-empty stays 0 meanwhile. The waiting byte starts one clock after the current byte's eighth tick. Status bit 3 is 1 while the shifter is busy.
- R8: `intr` is 1 when (rx-full and control bit 0) or (tx-empty and control bit 1). The control register is written and read with `rs`=2.
- R9: A strobe on `ready` while `cs` is 0 has no effect: `accept` stays 0 and no register changes.
- R10: `accept` pulses for one clock, one clock after a cycle with `cs` and `ready` both 1. `rdata` is valid in that same cycle. A read with `rs`=3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the address decoder |
| rs | input | 2 | Register select: 0 data, 1 status, 2 control, 3 unused |
| rw | input | 1 | 1 = read, 0 = write |
| ready | input | 1 | Request strobe from the bus master |
| wdata | input | 8 | Write data |
| accept | output | 1 | Access completed (response strobe) |
| rdata | output | 8 | Read data, valid while accept is 1 |
| intr | output | 1 | Interrupt request |
| rx_tick | input | 1 | Receive bit-clock enable |
| rx_bit | input | 1 | Serial data in |
| tx_tick | input | 1 | Transmit bit-clock enable |
| tx_bit | output | 1 | Serial data out, idle high |

## Verification
The hardest situations to reach are those in which both buffers of one direction are full at the same time. The first is a new receive byte half shifted in while the previous byte is still unread. The second is a second transmit byte waiting behind a shifter in mid-byte. The bench reaches both by splitting the bit ticks into partial runs with bus accesses between them. It reads the holding register after four bits of the next byte, and it writes the second transmit byte right after the first one has moved into the shifter. Overrun is brought about by sending two complete bytes with no read in between, and the bench then checks both the flag and which byte survived.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int ST_RXFULL  = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_OVERRUN = 2;
  localparam int ST_TXBUSY  = 3;
  localparam int CTL_RXIE   = 0;
  localparam int CTL_TXIE   = 1;
endpackage

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          bit_in,
  input  logic          rd_take,
  input  logic          clr_ovr,
  output logic [DW-1:0] hold,
  output logic          full,
  output logic          ovr
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [DW-1:0] nxt;
  logic          done;

  assign nxt  = {bit_in, sh[DW-1:1]};
  assign done = tick && (cnt == CW'(DW-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      hold <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (tick) begin
        sh  <= nxt;
        cnt <= done ? '0 : cnt + 1'b1;
      end
      if (done) begin
        hold <= nxt;
        full <= 1'b1;
      end else if (rd_take) begin
        full <= 1'b0;
      end
      if (clr_ovr) ovr <= 1'b0;
      if (done && full && !rd_take) ovr <= 1'b1;
    end
  end

  // R5
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(full));

  // R2
  full_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(tick));
endmodule

// File: rtl/sio_tx.sv
module sio_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          tx_bit,
  output logic          empty,
  output logic          busy
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] dbuf;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          load;

  assign load   = !busy && !empty;
  assign tx_bit = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbuf  <= '0;
      sh    <= '0;
      cnt   <= '0;
      empty <= 1'b1;
      busy  <= 1'b0;
    end else begin
      if (wr) begin
        dbuf  <= wdata;
        empty <= 1'b0;
      end else if (load) begin
        empty <= 1'b1;
      end
      if (load) begin
        sh   <= dbuf;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy && tick) begin
        sh  <= sh >> 1;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(DW-1)) busy <= 1'b0;
      end
    end
  end

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(tx_bit));

  // R7
  start_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(!empty));
endmodule

// File: rtl/sio_dbuf.sv
module sio_dbuf
  import sio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [1:0]    rs,
  input  logic          rw,
  input  logic          ready,
  input  logic [DW-1:0] wdata,
  output logic          accept,
  output logic [DW-1:0] rdata,
  output logic          intr,
  input  logic          rx_tick,
  input  logic          rx_bit,
  input  logic          tx_tick,
  output logic          tx_bit
);
  logic          req;
  logic          wr_data, rd_data, wr_stat, wr_ctrl;
  logic [1:0]    ctrl;
  logic [DW-1:0] rx_hold;
  logic          rx_full, rx_ovr, tx_empty, tx_busy;
  logic [DW-1:0] status;

  assign req     = cs && ready;
  assign wr_data = req && !rw && (rs == SEL_DATA);
  assign rd_data = req &&  rw && (rs == SEL_DATA);
  assign wr_stat = req && !rw && (rs == SEL_STAT);
  assign wr_ctrl = req && !rw && (rs == SEL_CTRL);

  always_comb begin
    status = '0;
    status[ST_RXFULL]  = rx_full;
    status[ST_TXEMPTY] = tx_empty;
    status[ST_OVERRUN] = rx_ovr;
    status[ST_TXBUSY]  = tx_busy;
  end

  sio_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(rx_tick), .bit_in(rx_bit),
    .rd_take(rd_data), .clr_ovr(wr_stat),
    .hold(rx_hold), .full(rx_full), .ovr(rx_ovr)
  );

  sio_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tx_tick), .wr(wr_data), .wdata(wdata),
    .tx_bit(tx_bit), .empty(tx_empty), .busy(tx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      accept <= 1'b0;
      rdata  <= '0;
    end else begin
      accept <= req;
      if (wr_ctrl) ctrl <= wdata[1:0];
      if (req && rw) begin
        case (rs)
          SEL_DATA: rdata <= rx_hold;
          SEL_STAT: rdata <= status;
          SEL_CTRL: rdata <= DW'(ctrl);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  assign intr = (rx_full && ctrl[CTL_RXIE]) || (tx_empty && ctrl[CTL_TXIE]);

  // R10
  accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(cs && ready));

  // R9
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs) |=> !accept);
endmodule

// File: tb/sio_dbuf_test.sv
`timescale 1ns/1ps
module sio_dbuf_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, rw = 1'b0, ready = 1'b0;
  logic [1:0] rs = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic accept, intr, tx_bit;
  logic [7:0] rdata;
  logic rx_tick = 1'b0, rx_bit = 1'b0, tx_tick = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] rv;

  localparam logic [7:0] RX_VEC [0:5] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hFF, 8'h00};
  localparam logic [7:0] TX_VEC [0:3] = '{8'h96, 8'h01, 8'hE7, 8'h40};

  always #4 clk = ~clk;

  sio_dbuf uut (
    .clk(clk), .rst(rst), .cs(cs), .rs(rs), .rw(rw), .ready(ready),
    .wdata(wdata), .accept(accept), .rdata(rdata), .intr(intr),
    .rx_tick(rx_tick), .rx_bit(rx_bit), .tx_tick(tx_tick), .tx_bit(tx_bit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic sel_cs, input logic [1:0] r, input logic rd,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cs = sel_cs; rs = r; rw = rd; wdata = d; ready = 1'b1;
    @(negedge clk);
    cs = 1'b0; ready = 1'b0;
    q = rdata;
    check("R10 accept", accept, sel_cs);
  endtask

  task automatic rx_bits(input logic [7:0] b, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      rx_bit = b[i]; rx_tick = 1'b1;
      @(negedge clk);
      rx_tick = 1'b0;
    end
  endtask

  task automatic tx_shift(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      check("R6 tx bit", tx_bit, b[i]);
      tx_tick = 1'b1;
      @(negedge clk);
      tx_tick = 1'b0;
    end
    check("R6 idle after byte", tx_bit, 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 intr", intr, 0);
    check("R1 tx_bit", tx_bit, 1);
    check("R1 accept", accept, 0);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R1 status", rv, 8'h02);

    // R2 R3 table of receive bytes
    foreach (RX_VEC[k]) begin
      rx_bits(RX_VEC[k], 0, 7);
      bus(1, 2'd1, 1, 8'h00, rv);
      check("R2 rx_full", rv[0], 1);
      bus(1, 2'd0, 1, 8'h00, rv);
      check("R2 rx byte", rv, RX_VEC[k]);
      bus(1, 2'd1, 1, 8'h00, rv);
      check("R3 cleared", rv, 8'h02);
    end

    // R4 double buffering on receive
    rx_bits(8'h5A, 0, 7);
    rx_bits(8'hC3, 0, 3);
    bus(1, 2'd0, 1, 8'h00, rv);
    check("R4 first byte", rv, 8'h5A);
    rx_bits(8'hC3, 4, 7);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R4 status no overrun", rv, 8'h03);
    bus(1, 2'd0, 1, 8'h00, rv);
    check("R4 second byte", rv, 8'hC3);

    // R5 overrun
    rx_bits(8'h11, 0, 7);
    rx_bits(8'h22, 0, 7);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R5 overrun status", rv, 8'h07);
    bus(1, 2'd1, 0, 8'h00, rv);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R5 overrun cleared", rv, 8'h03);
    bus(1, 2'd0, 1, 8'h00, rv);
    check("R5 newest byte kept", rv, 8'h22);

    // R6 table of transmit bytes
    foreach (TX_VEC[k]) begin
      bus(1, 2'd0, 0, TX_VEC[k], rv);
      @(negedge clk);
      tx_shift(TX_VEC[k]);
    end

    // R7 byte waiting behind a busy shifter
    bus(1, 2'd0, 0, 8'hB4, rv);
    @(negedge clk);
    bus(1, 2'd0, 0, 8'h6D, rv);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R7 waiting, busy", rv, 8'h08);
    tx_shift(8'hB4);
    @(negedge clk);
    tx_shift(8'h6D);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R7 drained", rv, 8'h02);

    // R8 interrupt enables
    bus(1, 2'd2, 0, 8'h01, rv);
    check("R8 rx ie, no data", intr, 0);
    rx_bits(8'h77, 0, 7);
    check("R8 rx intr", intr, 1);
    bus(1, 2'd0, 1, 8'h00, rv);
    check("R8 rx intr cleared", intr, 0);
    bus(1, 2'd2, 0, 8'h02, rv);
    check("R8 tx intr", intr, 1);
    bus(1, 2'd2, 1, 8'h00, rv);
    check("R8 ctrl readback", rv, 8'h02);
    bus(1, 2'd0, 0, 8'h0F, rv);
    check("R8 tx intr while full", intr, 0);
    @(negedge clk);
    check("R8 tx intr after move", intr, 1);
    tx_shift(8'h0F);
    bus(1, 2'd2, 0, 8'h00, rv);

    // R9 chip select gating
    bus(0, 2'd0, 0, 8'hAA, rv);
    bus(0, 2'd2, 0, 8'h03, rv);
    check("R9 no intr", intr, 0);
    check("R9 line idle", tx_bit, 1);
    bus(1, 2'd1, 1, 8'h00, rv);
    check("R9 status unchanged", rv, 8'h02);

    // R10 unused select
    bus(1, 2'd3, 1, 8'h00, rv);
    check("R10 unused reads 0", rv, 8'h00);
    @(negedge clk);
    check("R10 single pulse", accept, 0);

    done = 1'b1;
    finish_run();
  end
endmodule